// File: doc/BRIEF.md
# Eight-bit accumulator ALU with packed status flags

This block is the arithmetic core of a small eight-bit datapath. It holds an accumulator and a status byte. On each accepted operation it combines the accumulator with a second operand that has already been fetched. The result goes back into the accumulator, and the status byte is updated on the same clock edge. The operations are addition and subtraction, each with or without the incoming carry, bitwise AND, OR and XOR, complement, and four single-bit rotates. The rotates either wrap the end bit around or pass it through the carry.

The status byte packs sign, zero, nibble carry, even parity and carry into fixed bit positions. It can be read at any time. It can also be overwritten in one cycle, for example to restore a saved context after an interrupt. The restore strobe and an operation can arrive in the same cycle: the restore wins for the flags, and the operation still writes the accumulator. Operation codes 12 to 15 are reserved and do nothing.

Top module: `alu8_core`

## Requirements
- R1: Add (code 0) and add-with-carry (code 1) write A+B (plus CY for code 1) modulo 256. CY is set on a carry out of bit 7. AC is set on a carry from bit 3 into bit 4.
- R2: Subtract (code 2) and subtract-with-borrow (code 3) write A−B (minus CY for code 3) modulo 256. CY is set when a borrow occurs, that is when A < B (+CY). AC is set when the low nibble of A is at least the low nibble of B (+CY), meaning no borrow crosses out of the low nibble.
- R3: After every arithmetic or logic operation (codes 0–6), S equals bit 7 of the result, Z is 1 only for a zero result, and P is 1 when the result has an even number of one bits.
- R4: The status byte places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 always read 0, even after a restore that writes ones there.
- R5: AND (code 4), XOR (code 5) and OR (code 6) write the bitwise result and clear CY. AND sets AC, while XOR and OR clear it.
- R6: Complement (code 7) writes the bitwise inverse of A and leaves the whole status byte unchanged.
- R7: Rotate left (code 8) and rotate right (code 9) move the outgoing end bit into both the opposite end and CY. Rotate left through carry (code 10) and rotate right through carry (code 11) shift the old CY in and the outgoing bit into CY. Rotates change no flag other than CY.
- R8: With op_valid high, the accumulator and flags show the new values right after the next rising clock edge.
- R9: When op_valid is low, or the code is 12–15, the accumulator and the status byte keep their values (unless a restore is requested).
- R10: flag_load writes flag_wdata (reserved bits forced to 0) into the status byte on the next edge. It takes precedence over the flag update of a simultaneous operation, whose accumulator write still happens. Later carry-using operations see the restored CY.
- R11: While rst_n is low, the accumulator and the status byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform op_code this cycle |
| op_code | input | 4 | Operation select, codes 0–11 defined |
| operand | input | 8 | Second operand B |
| flag_load | input | 1 | Overwrite the status byte |
| flag_wdata | input | 8 | Status byte to restore |
| acc_q | output | 8 | Accumulator |
| flags_q | output | 8 | Packed status byte |

## Verification
The embedded assertions assume that every input is a known 0 or 1 at the sampling edge. They compare the flags against the accumulator value written on the same edge, so their antecedents exclude cycles where flag_load overrides the flags. The stimulus changes inputs only on falling edges. It draws codes from the full four-bit range, so reserved codes appear, and it lets op_valid and flag_load collide. Directed cases cover the nibble-carry and carry-out edges, a zero result, and a restore that writes ones into the reserved bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBB = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_XOR = 4'd5;
  localparam logic [3:0] OP_OR  = 4'd6;
  localparam logic [3:0] OP_CPL = 4'd7;
  localparam logic [3:0] OP_RLC = 4'd8;
  localparam logic [3:0] OP_RRC = 4'd9;
  localparam logic [3:0] OP_RAL = 4'd10;
  localparam logic [3:0] OP_RAR = 4'd11;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_CY = 0;
  localparam logic [DW-1:0] FLAG_MASK = 8'hD5;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic even_ones(input logic [DW-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic [DW-1:0] pack_flags(input flags_t f);
    logic [DW-1:0] b;
    b = '0;
    b[FB_S]  = f.s;
    b[FB_Z]  = f.z;
    b[FB_AC] = f.ac;
    b[FB_P]  = f.p;
    b[FB_CY] = f.cy;
    return b;
  endfunction
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W    = 8,
  parameter int LO_W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         nib_carry,
  output logic         top_carry
);
  localparam int HI_W = W - LO_W;

  logic [LO_W:0] lo_sum;
  logic [HI_W:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
    hi_sum = {1'b0, a[W-1:LO_W]} + {1'b0, b[W-1:LO_W]} + {{HI_W{1'b0}}, lo_sum[LO_W]};
  end

  assign sum       = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
  assign nib_carry = lo_sum[LO_W];
  assign top_carry = hi_sum[HI_W];
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         ac_out
);
  always_comb begin
    res    = a;
    cy_out = 1'b0;
    ac_out = 1'b0;
    case (op)
      OP_AND: begin res = a & b; ac_out = 1'b1; end
      OP_XOR: res = a ^ b;
      OP_OR:  res = a | b;
      OP_CPL: res = ~a;
      OP_RLC: begin res = {a[W-2:0], a[W-1]}; cy_out = a[W-1]; end
      OP_RRC: begin res = {a[0], a[W-1:1]};   cy_out = a[0];   end
      OP_RAL: begin res = {a[W-2:0], cy_in};  cy_out = a[W-1]; end
      OP_RAR: begin res = {cy_in, a[W-1:1]};  cy_out = a[0];   end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore,
  input  logic [DW-1:0] restore_data,
  input  logic          upd_all,
  input  logic          upd_cy,
  input  flags_t        nxt,
  output logic [DW-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (restore) begin
      flags_q <= restore_data & FLAG_MASK;
    end else if (upd_all) begin
      flags_q <= pack_flags(nxt);
    end else if (upd_cy) begin
      flags_q[FB_CY] <= nxt.cy;
    end
  end

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~FLAG_MASK) == '0);

  assert_restore_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> flags_q == ($past(restore_data) & FLAG_MASK));

  assert_cy_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_cy && !restore && !upd_all) |=>
      (flags_q[DW-1:1] == $past(flags_q[DW-1:1])));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [DW-1:0] operand,
  input  logic          flag_load,
  input  logic [DW-1:0] flag_wdata,
  output logic [DW-1:0] acc_q,
  output logic [DW-1:0] flags_q
);
  logic is_add, is_sub, is_arith, is_logic, is_cpl, is_rot, op_known, do_op;
  logic carry_used, cin, nib_c, top_c, cy_cur;
  logic cy_bit, ac_bit;
  logic [DW-1:0] b_eff, sum, bit_res, result;
  flags_t nxt;

  assign cy_cur     = flags_q[FB_CY];
  assign is_add     = (op_code == OP_ADD) || (op_code == OP_ADC);
  assign is_sub     = (op_code == OP_SUB) || (op_code == OP_SBB);
  assign is_arith   = is_add || is_sub;
  assign is_logic   = (op_code == OP_AND) || (op_code == OP_XOR) || (op_code == OP_OR);
  assign is_cpl     = (op_code == OP_CPL);
  assign is_rot     = (op_code >= OP_RLC) && (op_code <= OP_RAR);
  assign op_known   = (op_code <= OP_RAR);
  assign do_op      = op_valid && op_known;
  assign carry_used = ((op_code == OP_ADC) || (op_code == OP_SBB)) && cy_cur;

  // Subtraction adds the inverted operand; the borrow-in becomes an inverted carry-in.
  assign b_eff = is_sub ? ~operand : operand;
  assign cin   = is_sub ? ~carry_used : carry_used;

  alu8_adder #(.W(DW), .LO_W(NW)) u_add (
    .a(acc_q), .b(b_eff), .cin(cin),
    .sum(sum), .nib_carry(nib_c), .top_carry(top_c)
  );

  alu8_bitops #(.W(DW)) u_bit (
    .a(acc_q), .b(operand), .op(op_code), .cy_in(cy_cur),
    .res(bit_res), .cy_out(cy_bit), .ac_out(ac_bit)
  );

  assign result = is_arith ? sum : bit_res;

  always_comb begin
    nxt.s  = result[DW-1];
    nxt.z  = (result == '0);
    nxt.ac = is_arith ? nib_c : ac_bit;
    nxt.p  = even_ones(result);
    nxt.cy = is_arith ? (is_sub ? ~top_c : top_c) : cy_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (do_op) acc_q <= result;
  end

  alu8_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n),
    .restore(flag_load), .restore_data(flag_wdata),
    .upd_all(do_op && (is_arith || is_logic)),
    .upd_cy(do_op && is_rot),
    .nxt(nxt), .flags_q(flags_q)
  );

  assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_op && (is_arith || is_logic) && !flag_load) |=> flags_q[FB_S] == acc_q[DW-1]);

  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_op && (is_arith || is_logic) && !flag_load) |=> flags_q[FB_Z] == (acc_q == '0));

  assert_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (do_op && (is_arith || is_logic) && !flag_load) |=> flags_q[FB_P] == ~(^acc_q));

  assert_logic_cy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_op && is_logic && !flag_load) |=> !flags_q[FB_CY]);

  assert_cpl_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_op && is_cpl && !flag_load) |=> ($stable(flags_q) && acc_q == ~$past(acc_q)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_op && !flag_load) |=> ($stable(acc_q) && $stable(flags_q)));
endmodule

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] operand = '0;
  logic       flag_load = 1'b0;
  logic [7:0] flag_wdata = '0;
  logic [7:0] acc_q, flags_q;

  int total = 0;
  int bad = 0;
  logic [7:0] acc_m = '0;
  logic [7:0] flg_m = '0;

  always #2.5 clk = ~clk;

  alu8_core uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .flag_load(flag_load), .flag_wdata(flag_wdata),
    .acc_q(acc_q), .flags_q(flags_q)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_flags(input int r, input logic ac, input logic cy);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    return {r[7], (r == 0), 1'b0, ac, 1'b0, (ones % 2 == 0), 1'b0, cy};
  endfunction

  function automatic string tag_of(input logic v, input logic [3:0] op, input logic fl);
    if (fl) return "R10";
    if (!v || op > 4'd11) return "R9";
    if (op <= 4'd1) return "R1";
    if (op <= 4'd3) return "R2";
    if (op <= 4'd6) return "R5";
    if (op == 4'd7) return "R6";
    return "R7";
  endfunction

  // Drive at a falling edge, update the model, check at the next falling edge.
  task automatic step(input logic v, input logic [3:0] op, input logic [7:0] b,
                      input logic fl, input logic [7:0] fw);
    int a = acc_m;
    int bi = b;
    int c = flg_m[0];
    int r;
    logic [7:0] na = acc_m;
    logic [7:0] nf = flg_m;
    string tag = tag_of(v, op, fl);
    op_valid = v; op_code = op; operand = b; flag_load = fl; flag_wdata = fw;
    if (v) begin
      case (op)
        4'd0: begin r = (a + bi) % 256; na = r[7:0]; nf = mk_flags(r, (a%16 + bi%16) > 15, (a + bi) > 255); end
        4'd1: begin r = (a + bi + c) % 256; na = r[7:0]; nf = mk_flags(r, (a%16 + bi%16 + c) > 15, (a + bi + c) > 255); end
        4'd2: begin r = (a - bi + 256) % 256; na = r[7:0]; nf = mk_flags(r, (a%16) >= (bi%16), a < bi); end
        4'd3: begin r = (a - bi - c + 512) % 256; na = r[7:0]; nf = mk_flags(r, (a%16) >= (bi%16 + c), a < bi + c); end
        4'd4: begin r = a & bi; na = r[7:0]; nf = mk_flags(r, 1'b1, 1'b0); end
        4'd5: begin r = a ^ bi; na = r[7:0]; nf = mk_flags(r, 1'b0, 1'b0); end
        4'd6: begin r = a | bi; na = r[7:0]; nf = mk_flags(r, 1'b0, 1'b0); end
        4'd7: na = ~acc_m;
        4'd8: begin na = (acc_m << 1) | (acc_m >> 7); nf[0] = acc_m[7]; end
        4'd9: begin na = (acc_m >> 1) | (acc_m << 7); nf[0] = acc_m[0]; end
        4'd10: begin na = (acc_m << 1) | c[7:0]; nf[0] = acc_m[7]; end
        4'd11: begin na = (acc_m >> 1) | (c[7:0] << 7); nf[0] = acc_m[0]; end
        default: ;
      endcase
    end
    if (fl) nf = fw & 8'hD5;
    acc_m = na; flg_m = nf;
    @(negedge clk);
    check(acc_q == acc_m, tag, "acc", acc_q, acc_m);
    check(flags_q == flg_m, tag, "flags", flags_q, flg_m);
    check((flags_q & 8'h2A) == 8'h00, "R4", "reserved bits", flags_q, flags_q & 8'hD5);
  endtask

  task automatic set_acc(input logic [7:0] val);
    step(1'b1, 4'd4, 8'h00, 1'b0, 8'h00);
    step(1'b1, 4'd6, val, 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL R8 watchdog actual=%02h expected=%02h", 8'hFF, 8'h00);
    finish_run();
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(acc_q == 8'h00, "R11", "acc in reset", acc_q, 8'h00);
    check(flags_q == 8'h00, "R11", "flags in reset", flags_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R3: 0x47 + 0x51 gives 0x98, only S set.
    set_acc(8'h47);
    step(1'b1, 4'd0, 8'h51, 1'b0, 8'h00);
    check(acc_q == 8'h98, "R8", "example sum", acc_q, 8'h98);
    check(flags_q == 8'h80, "R3", "example flags", flags_q, 8'h80);

    // R1: 0xFF + 0x01 wraps to zero with Z, AC, P, CY.
    set_acc(8'hFF);
    step(1'b1, 4'd0, 8'h01, 1'b0, 8'h00);
    check(flags_q == 8'h55, "R1", "wrap flags", flags_q, 8'h55);

    // R10 / R4: restore ones everywhere, reserved bits stay 0.
    step(1'b0, 4'd0, 8'h00, 1'b1, 8'hFF);
    check(flags_q == 8'hD5, "R10", "restore all ones", flags_q, 8'hD5);
    // R7: rotate through carry shifts in the restored CY.
    step(1'b1, 4'd10, 8'h00, 1'b0, 8'h00);
    check(acc_q == 8'h01, "R7", "RAL carry in", acc_q, 8'h01);
    check(flags_q == 8'hD4, "R7", "RAL flags", flags_q, 8'hD4);

    // R2: 0x10 - 0x01 borrows from the nibble, no overall borrow.
    set_acc(8'h10);
    step(1'b1, 4'd2, 8'h01, 1'b0, 8'h00);
    check(flags_q[4] == 1'b0, "R2", "nibble borrow AC", flags_q, flg_m);
    step(1'b1, 4'd2, 8'h20, 1'b0, 8'h00);
    check(flags_q[0] == 1'b1, "R2", "borrow CY", flags_q, flg_m);

    // R10: collision, flags restored while the acc still updates.
    step(1'b1, 4'd0, 8'h05, 1'b1, 8'h01);
    step(1'b1, 4'd1, 8'h00, 1'b0, 8'h00);
    // R6 / R9: complement and a reserved code.
    step(1'b1, 4'd7, 8'h00, 1'b0, 8'h00);
    step(1'b1, 4'd13, 8'hAA, 1'b0, 8'h00);

    for (int i = 0; i < 600; i++) begin
      logic v = ($urandom % 100) < 85;
      logic fl = ($urandom % 100) < 10;
      step(v, 4'($urandom % 16), 8'($urandom), fl, 8'($urandom));
    end
    finish_run();
  end
endmodule